// File: doc/BRIEF.md
# Video Sync Timing Lock Checker

This block sits on the pixel-clock side of a video input port. It watches horizontal sync, vertical sync and an optional data-enable that come from an outside video source. It measures their structure against a programmed timing set. On the horizontal axis the set holds sync width, back porch, active width and front porch, all counted in pixel clocks. On the vertical axis it holds the same four values, counted in horizontal sync periods.

The checker raises `locked` once one whole frame matches the programmed set, from one vertical sync leading edge to the next. Any mismatch drops `locked` at once. Each kind of fault also sets a sticky bit in `err_status`, which stays set until `err_clr` is pulsed. The strobes `line_start` and `frame_start` mark the leading edges of the sync signals after they have been synchronized. Downstream capture logic can use them for alignment.

Both sync inputs have their own polarity select. Every input passes through a two-flop synchronizer before any check is made.

Top module: `video_timing_lock`

## Requirements
- R1: With `hs_pol` or `vs_pol` at 1 the matching pin is active low; at 0 it is active high. Both polarities are handled the same way after normalization.
- R2: Once a horizontal sync leading edge has been seen, each line must meet two conditions, or `err_status` bit 0 (horizontal) is set:
  - sync stays active for exactly `h_pw` clocks;
  - the next leading edge comes exactly `h_pw+h_bp+h_act+h_fp` clocks after the previous one.
- R3: Vertical timing is counted in horizontal sync leading edges, starting from an aligned frame start. Either of the following sets `err_status` bit 1 (vertical):
  - at some line's leading edge, the vertical sync level does not match "line index < `v_pw`";
  - the frame length differs from `v_pw+v_bp+v_act+v_fp` lines.
- R4: A vertical sync edge (leading or trailing) that does not fall in the same clock as a horizontal sync leading edge sets `err_status` bit 2 (alignment).
- R5: With `de_mode`=1, data-enable must be high exactly on the pixels that are inside both the active columns and the active lines. Any other value sets `err_status` bit 3. With `de_mode`=0 the data-enable pin has no effect.
- R6: If any of `h_pw`, `h_act`, `v_pw`, `v_act` is zero, `err_status` bit 4 (config) is set and `locked` stays low.
- R7: `locked` rises exactly one clock after the `frame_start` strobe that closes an error-free frame. That frame must have begun at the `frame_start` strobe before it.
- R8: Any error clears `locked` on the same clock edge that records it in `err_status`. After that, one more full clean frame is needed before lock returns.
- R9: Zero values for the horizontal and vertical porches are legal, and such timing locks.
- R10: Bits in `err_status` stay set until a one-clock `err_clr` pulse clears them.
- R11: `line_start` and `frame_start` each pulse for one clock, two clock edges after the corresponding sync leading edge is applied at the pin. `frame_start` pulses only when the vertical and horizontal leading edges coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_pin | input | 1 | Raw horizontal sync |
| vs_pin | input | 1 | Raw vertical sync |
| de_pin | input | 1 | Raw data-enable |
| hs_pol | input | 1 | 1 = horizontal sync active low |
| vs_pol | input | 1 | 1 = vertical sync active low |
| de_mode | input | 1 | 1 = check data-enable |
| h_pw | input | HW | Horizontal sync width, clocks |
| h_bp | input | HW | Horizontal back porch, clocks |
| h_act | input | HW | Active width, clocks |
| h_fp | input | HW | Horizontal front porch, clocks |
| v_pw | input | VW | Vertical sync width, lines |
| v_bp | input | VW | Vertical back porch, lines |
| v_act | input | VW | Active height, lines |
| v_fp | input | VW | Vertical front porch, lines |
| err_clr | input | 1 | Clears sticky error bits |
| locked | output | 1 | Timing matches programmed set |
| err_status | output | 5 | Sticky errors {config, de, align, vert, horiz} |
| frame_start | output | 1 | Aligned frame start strobe |
| line_start | output | 1 | Line start strobe |

## Verification
The hardest situation to reach is a lock that is lost and then regained. The checker must be locked, a single fault must land in the middle of a frame, and exactly one clean frame must then pass before the relock.

The bench uses a pixel-accurate stream generator. It can lengthen one chosen line by a single pixel, shift vertical sync by one pixel, or drive one stray data-enable pixel. It also records the clock of each strobe, of each lock edge and of each error edge. This lets it compare the timing of the lock drop against the timing of the error, and the timing of the relock against the frame boundaries.

// File: rtl/vlk_pkg.sv
// Shared definitions for the video timing lock checker.
// Assumes: error bit positions below are the ones software reads.
package vlk_pkg;
    localparam int NERR  = 5;
    localparam int ERR_H = 0;
    localparam int ERR_V = 1;
    localparam int ERR_A = 2;
    localparam int ERR_D = 3;
    localparam int ERR_C = 4;

    typedef logic [NERR-1:0] err_vec_t;

    typedef enum logic {
        LK_IDLE  = 1'b0,
        LK_CHECK = 1'b1
    } lk_state_t;
endpackage

// File: rtl/vlk_sync_in.sv
// Two-flop synchronizer with polarity normalization and edge detection
// for N independent pins. Assumes pins are asynchronous to clk.
// All lanes have identical latency, so relative alignment is preserved.
module vlk_sync_in #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic s1_q, s2_q, prev_q;

        // capture the pin, normalized to active-high, and keep one history bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin[i] ^ pol[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign lvl[i]  = s2_q;
        assign rise[i] = s2_q & ~prev_q;
        assign fall[i] = ~s2_q & prev_q;
    end
endmodule

// File: rtl/vlk_hcheck.sv
// Horizontal checker: tracks pixel position since the last horizontal
// sync leading edge and validates sync width and line period.
// Assumes: normalized active-high sync from vlk_sync_in.
module vlk_hcheck #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_lvl,
    input  logic          hs_rise,
    input  logic [HW-1:0] h_pw,
    input  logic [HW-1:0] h_bp,
    input  logic [HW-1:0] h_act,
    input  logic [HW-1:0] h_fp,
    output logic          h_valid,
    output logic          h_err,
    output logic          h_active
);
    localparam int PW = HW + 2;

    logic [PW-1:0] htotal, act_lo, act_hi, cur_pos, pos_q;
    logic          hvalid_q, chk, too_long, bad_period, bad_level;

    // derived line geometry
    always_comb begin
        act_lo = PW'(h_pw) + PW'(h_bp);
        act_hi = act_lo + PW'(h_act);
        htotal = act_hi + PW'(h_fp);
    end

    // current position and the three horizontal fault conditions
    always_comb begin
        cur_pos    = hs_rise ? '0 : pos_q;
        chk        = hvalid_q | hs_rise;
        too_long   = hvalid_q & ~hs_rise & (pos_q == htotal);
        bad_period = hvalid_q & hs_rise & (pos_q != htotal);
        bad_level  = chk & (hs_lvl != (cur_pos < PW'(h_pw)));
        h_err      = too_long | bad_period | bad_level;
        h_active   = chk & (cur_pos >= act_lo) & (cur_pos < act_hi);
        h_valid    = chk;
    end

    // position counter; restarts on every leading edge, stops on a missing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hvalid_q <= 1'b0;
            pos_q    <= '0;
        end else if (hs_rise) begin
            hvalid_q <= 1'b1;
            pos_q    <= PW'(1);
        end else if (too_long) begin
            hvalid_q <= 1'b0;
        end else if (hvalid_q) begin
            pos_q    <= pos_q + PW'(1);
        end
    end

    // R2
    missing_edge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        too_long |=> !hvalid_q);

    // R2
    edge_validates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (hvalid_q && pos_q == PW'(1)));
endmodule

// File: rtl/vlk_vcheck.sv
// Vertical checker: counts horizontal sync leading edges from an aligned
// frame start, validates vertical sync width in lines, frame length and
// edge alignment. Assumes normalized syncs with equal latency.
module vlk_vcheck #(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_rise,
    input  logic          vs_lvl,
    input  logic          vs_rise,
    input  logic          vs_fall,
    input  logic [VW-1:0] v_pw,
    input  logic [VW-1:0] v_bp,
    input  logic [VW-1:0] v_act,
    input  logic [VW-1:0] v_fp,
    output logic          v_valid,
    output logic          v_err,
    output logic          a_err,
    output logic          v_active,
    output logic          fstart
);
    localparam int LW = VW + 2;

    logic [LW-1:0] vtotal, act_lo, act_hi, lcur, lpos_q, lidx_q;
    logic          vvalid_q, chk, bad_total, too_long, bad_level, misalign;

    // derived frame geometry
    always_comb begin
        act_lo = LW'(v_pw) + LW'(v_bp);
        act_hi = act_lo + LW'(v_act);
        vtotal = act_hi + LW'(v_fp);
    end

    // line-level fault conditions, evaluated on horizontal leading edges
    always_comb begin
        fstart    = vs_rise & hs_rise;
        misalign  = (vs_rise | vs_fall) & ~hs_rise;
        lcur      = fstart ? '0 : lpos_q;
        chk       = hs_rise & (vvalid_q | fstart);
        bad_total = fstart & vvalid_q & (lpos_q != vtotal);
        too_long  = hs_rise & ~fstart & vvalid_q & (lpos_q == vtotal);
        bad_level = chk & (vs_lvl != (lcur < LW'(v_pw)));
        v_err     = bad_total | too_long | bad_level;
        a_err     = misalign;
        v_active  = vvalid_q & (lidx_q >= act_lo) & (lidx_q < act_hi);
        v_valid   = vvalid_q;
    end

    // line counter and frame-valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vvalid_q <= 1'b0;
            lpos_q   <= '0;
            lidx_q   <= '0;
        end else if (misalign) begin
            vvalid_q <= 1'b0;
        end else if (hs_rise) begin
            lidx_q <= lcur;
            lpos_q <= lcur + LW'(1);
            if (fstart)
                vvalid_q <= 1'b1;
            else if (too_long)
                vvalid_q <= 1'b0;
        end
    end

    // R4
    misalign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && !hs_rise) |=> !vvalid_q);

    // R3
    frame_start_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> (vvalid_q && lidx_q == '0));
endmodule

// File: rtl/video_timing_lock.sv
// Top of the video timing lock checker. Synchronizes the pins, runs the
// horizontal and vertical checkers, checks data-enable, keeps sticky error
// bits and sequences lock. Assumes timing inputs are quasi-static.
module video_timing_lock
    import vlk_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_pin,
    input  logic          vs_pin,
    input  logic          de_pin,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_mode,
    input  logic [HW-1:0] h_pw,
    input  logic [HW-1:0] h_bp,
    input  logic [HW-1:0] h_act,
    input  logic [HW-1:0] h_fp,
    input  logic [VW-1:0] v_pw,
    input  logic [VW-1:0] v_bp,
    input  logic [VW-1:0] v_act,
    input  logic [VW-1:0] v_fp,
    input  logic          err_clr,
    output logic          locked,
    output logic [4:0]    err_status,
    output logic          frame_start,
    output logic          line_start
);
    logic [2:0] lvl, rise, fall;
    logic       h_valid, h_err, h_active;
    logic       v_valid, v_err, a_err, v_active, fstart;
    logic       cfg_bad, de_err, err_any;
    err_vec_t   err_now, sticky_q;
    lk_state_t  st_q;
    logic       locked_q;

    vlk_sync_in #(.N(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({de_pin, vs_pin, hs_pin}),
        .pol  ({1'b0, vs_pol, hs_pol}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    vlk_hcheck #(.HW(HW)) u_h (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_lvl  (lvl[0]),
        .hs_rise (rise[0]),
        .h_pw    (h_pw),
        .h_bp    (h_bp),
        .h_act   (h_act),
        .h_fp    (h_fp),
        .h_valid (h_valid),
        .h_err   (h_err),
        .h_active(h_active)
    );

    vlk_vcheck #(.VW(VW)) u_v (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_rise (rise[0]),
        .vs_lvl  (lvl[1]),
        .vs_rise (rise[1]),
        .vs_fall (fall[1]),
        .v_pw    (v_pw),
        .v_bp    (v_bp),
        .v_act   (v_act),
        .v_fp    (v_fp),
        .v_valid (v_valid),
        .v_err   (v_err),
        .a_err   (a_err),
        .v_active(v_active),
        .fstart  (fstart)
    );

    // collect this cycle's faults into one vector
    always_comb begin
        cfg_bad = (h_pw == '0) | (h_act == '0) | (v_pw == '0) | (v_act == '0);
        de_err  = de_mode & h_valid & v_valid & (lvl[2] != (h_active & v_active));
        err_now        = '0;
        err_now[ERR_H] = h_err;
        err_now[ERR_V] = v_err;
        err_now[ERR_A] = a_err;
        err_now[ERR_D] = de_err;
        err_now[ERR_C] = cfg_bad;
        err_any = |err_now;
    end

    // sticky error bits; new faults win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= '0;
        else
            sticky_q <= (err_clr ? '0 : sticky_q) | err_now;
    end

    // lock sequencer: arm on a clean frame start, lock on the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= LK_IDLE;
            locked_q <= 1'b0;
        end else if (err_any) begin
            st_q     <= LK_IDLE;
            locked_q <= 1'b0;
        end else if (fstart) begin
            if (st_q == LK_CHECK)
                locked_q <= 1'b1;
            st_q <= LK_CHECK;
        end
    end

    assign locked      = locked_q;
    assign err_status  = sticky_q;
    assign frame_start = fstart;
    assign line_start  = rise[0];

    // R8
    err_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> !locked);

    // R6
    cfg_blocks_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (!locked && err_status[ERR_C]));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_status & $past(err_status)) == $past(err_status)));

    // R7
    lock_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(frame_start));
endmodule

// File: tb/video_timing_lock_bench.sv
module video_timing_lock_bench;
    localparam int HW = 12;
    localparam int VW = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, hs_pin, vs_pin, de_pin, hs_pol, vs_pol, de_mode, err_clr;
    logic [HW-1:0] h_pw, h_bp, h_act, h_fp;
    logic [VW-1:0] v_pw, v_bp, v_act, v_fp;
    logic locked, frame_start, line_start;
    logic [4:0] err_status;

    video_timing_lock #(.HW(HW), .VW(VW)) u_video_timing_lock (
        .clk(clk), .rst_n(rst_n), .hs_pin(hs_pin), .vs_pin(vs_pin), .de_pin(de_pin),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_mode(de_mode),
        .h_pw(h_pw), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
        .v_pw(v_pw), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
        .err_clr(err_clr), .locked(locked), .err_status(err_status),
        .frame_start(frame_start), .line_start(line_start)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // source stream timing
    int s_hpw, s_hbp, s_hact, s_hfp, s_vpw, s_vbp, s_vact, s_vfp;
    int de_bad, vs_shift, bad_line;

    typedef struct packed {
        logic [7:0] phpw, phbp, phact, phfp, pvpw, pvbp, pvact, pvfp;
        logic [7:0] shpw, shbp, shact, shfp, svpw, svbp, svact, svfp;
        logic       hpol, vpol, dem, deb, vsh, exp_lock;
        logic [4:0] exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R2 R3 R5: nominal, de checked
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'b00000},
        // R1: both syncs active low
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,5'b00000},
        // R9: zero porches
        '{8'd2,8'd0,8'd8,8'd0,8'd2,8'd0,8'd4,8'd0, 8'd2,8'd0,8'd8,8'd0,8'd2,8'd0,8'd4,8'd0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'b00000},
        // R2: line one pixel long
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd3,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'b00001},
        // R3: frame one line long
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'b00010},
        // R3: vertical sync one line wide
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd3,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'b00010},
        // R4: vertical edges one pixel late
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00100},
        // R5: stray de pixel, de checked
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,5'b01000},
        // R5: stray de pixel, de ignored
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,5'b00000},
        // R6: zero active height programmed
        '{8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd0,8'd2, 8'd2,8'd2,8'd8,8'd2,8'd2,8'd2,8'd4,8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'b10010}
    };

    task automatic load(input vec_t v);
        h_pw = v.phpw; h_bp = v.phbp; h_act = v.phact; h_fp = v.phfp;
        v_pw = v.pvpw; v_bp = v.pvbp; v_act = v.pvact; v_fp = v.pvfp;
        s_hpw = v.shpw; s_hbp = v.shbp; s_hact = v.shact; s_hfp = v.shfp;
        s_vpw = v.svpw; s_vbp = v.svbp; s_vact = v.svact; s_vfp = v.svfp;
        hs_pol = v.hpol; vs_pol = v.vpol; de_mode = v.dem;
        de_bad = v.deb; vs_shift = v.vsh; bad_line = -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; err_clr = 1'b0;
        hs_pin = hs_pol; vs_pin = vs_pol; de_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic gen_frames(input int n);
        int htot, vtot, hlo, hhi, vlo, vhi;
        logic hs, vs, de, va;
        htot = s_hpw + s_hbp + s_hact + s_hfp;
        vtot = s_vpw + s_vbp + s_vact + s_vfp;
        hlo = s_hpw + s_hbp; hhi = hlo + s_hact;
        vlo = s_vpw + s_vbp; vhi = vlo + s_vact;
        for (int f = 0; f < n; f++) begin
            for (int l = 0; l < vtot; l++) begin
                for (int p = 0; p < htot + ((l == bad_line) ? 1 : 0); p++) begin
                    @(negedge clk);
                    hs = (p < s_hpw);
                    vs = (l == 0 && p >= vs_shift) || (l > 0 && l < s_vpw) ||
                         (l == s_vpw && p < vs_shift);
                    va = (l >= vlo) && (l < vhi);
                    de = (va && p >= hlo && p < hhi) || (de_bad != 0 && l == vlo && p == hhi);
                    hs_pin = hs ^ hs_pol;
                    vs_pin = vs ^ vs_pol;
                    de_pin = de;
                end
            end
        end
    endtask

    // event monitor sampled away from the active edge
    int cyc = 0, fs_n = 0, lock_rise = -1, lock_fall = -1, e0_rise = -1;
    int fs_cyc [4];
    logic mon_clr = 1'b0, lk_q = 1'b0, e0_q = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            fs_n = 0; lock_rise = -1; lock_fall = -1; e0_rise = -1;
        end else begin
            if (frame_start) begin
                if (fs_n < 4) fs_cyc[fs_n] = cyc;
                fs_n++;
            end
            if (locked && !lk_q && lock_rise < 0) lock_rise = cyc;
            if (!locked && lk_q && lock_fall < 0) lock_fall = cyc;
            if (err_status[0] && !e0_q && e0_rise < 0) e0_rise = cyc;
        end
        lk_q = locked;
        e0_q = err_status[0];
    end

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; err_clr = 1'b0;
        load(TBL[0]);
        do_reset();

        // reset state
        @(negedge clk);
        check("R10 reset err_status", err_status, 0);
        check("R7 reset locked", locked, 0);
        check("R11 reset strobes", {frame_start, line_start}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            load(TBL[i]);
            do_reset();
            gen_frames(3);
            @(negedge clk);
            check($sformatf("R1-R9 vec%0d locked", i), locked, TBL[i].exp_lock);
            check($sformatf("R1-R9 vec%0d err_status", i), err_status, TBL[i].exp_err);
        end

        // R11: strobe timing from pin edge
        load(TBL[0]);
        do_reset();
        @(negedge clk);
        hs_pin = 1'b1; vs_pin = 1'b1;
        @(negedge clk);
        check("R11 strobes one edge after pin", {frame_start, line_start}, 0);
        @(negedge clk);
        check("R11 strobes two edges after pin", {frame_start, line_start}, 3);
        @(negedge clk);
        check("R11 strobes single cycle", {frame_start, line_start}, 0);

        // R7: exact lock cycle, frame spacing
        load(TBL[0]);
        do_reset();
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        gen_frames(3);
        @(negedge clk);
        check("R7 frame spacing", fs_cyc[1] - fs_cyc[0], 140);
        check("R7 lock one clock after closing frame start", lock_rise, fs_cyc[1] + 1);

        // R8: one long line drops lock at the error edge, then relock
        bad_line = 5;
        gen_frames(1);
        bad_line = -1;
        check("R8 lock drop coincides with error", lock_fall, e0_rise);
        check("R8 lock dropped", (lock_fall > 0) ? 1 : 0, 1);
        gen_frames(1);
        check("R8 no relock after one frame start", locked, 0);
        gen_frames(1);
        @(negedge clk);
        check("R8 relocked after clean frame", locked, 1);

        // R10: sticky until clear
        check("R10 horiz bit held", err_status, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        check("R10 cleared by strobe", err_status, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule